// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Synchronized Input

This block is one general-purpose I/O port of a small controller. Software reaches it through a plain register bus with three registers: a direction register, a level register and a sampled-input register. For each pin, the direction and level bits set three pad controls: drive enable, drive value and weak pull-up enable. A chip-wide input turns off every pull-up. The pad controls are meant for a pad model that sits outside the block.

The pad's digital level comes back through a two-stage sampler. The first stage is a latch that is open while the clock is high. The second is a register that loads on the rising edge. The sampled value can be read whatever the direction setting. A write of ones to the sampled-input address flips the matching level bits, so one bus write can toggle a pin.

The block also has a low-power input. While it is asserted, each pad input is forced low before it reaches the sampler. A per-pin keep-awake input exempts a pin from this clamp, for pins that must still be seen, such as wake-up sources.

Top module: `gpio_port_sync`

## Requirements
- R1: While rst_n is low and right after it is released, the direction, level and sampled registers read 0, and pad_oe and pad_pu are 0 on all pins.
- R2: Bus address 1 is the direction register and address 2 is the level register. A write with bus_wr high loads bus_wdata at the rising edge. bus_rdata returns the addressed register in the same cycle when bus_rd is high. bus_rdata is 0 when bus_rd is low or when the address is 3.
- R3: A write to address 0 (the sampled-input address) inverts each level bit whose write-data bit is 1 and leaves the others unchanged. This holds whatever the direction bits hold.
- R4: A pin with direction 0 and level 0 has pad_oe=0 and pad_pu=0.
- R5: A pin with direction 0 and level 1 has pad_pu=1 only when pullup_off is 0. With pullup_off at 1, pad_pu is 0.
- R6: A pin with direction 1 has pad_oe=1 and pad_pu=0, and pad_out equals its level bit.
- R7: Address 0 reads the sampled pad levels whatever the direction setting. On an output pin it returns the level the pin drives.
- R8: A pad level that is present while the clock is high becomes readable after the next rising edge. After a write that changes the level of an output pin, a read in the following cycle still returns the old level. The new level reads one cycle later.
- R9: While sleep_req is 1, a pin whose wake_keep bit is 0 samples as 0. A pin whose wake_keep bit is 1 keeps following its pad.
- R10: pad_pu is 0 on every pin while rst_n is low, including when reset is asserted in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| bus_addr | input | 2 | Register select: 0 sampled input or toggle, 1 direction, 2 level |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| pullup_off | input | 1 | Disables all pull-ups |
| sleep_req | input | 1 | Low-power request, clamps pad inputs low |
| wake_keep | input | 8 | Per-pin exemption from the sleep clamp |
| pad_in | input | 8 | Digital level seen at each pad |
| pad_oe | output | 8 | Pad drive enable |
| pad_out | output | 8 | Pad drive value |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
The timing properties assume that pad_in, sleep_req and wake_keep change only while the clock is high and stay steady across the falling edge. A value then belongs to exactly one sampling window, and the sampled register can be tied to what the inputs held one cycle earlier. They also assume that reset is released just after a rising edge. The bench meets these assumptions by changing every input and the external pad level a few nanoseconds after each rising edge and finishing all bus reads before the falling edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned SEL_W = 2;

  // Register selects; address 0 doubles as the toggle port on writes
  typedef enum logic [SEL_W-1:0] {
    SEL_SAMPLE = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_LEVEL  = 2'd2,
    SEL_NONE   = 2'd3
  } gp_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     lvl_q
);

  logic [W-1:0] dir_d;
  logic [W-1:0] lvl_d;

  always_comb begin
    dir_d = dir_q;
    lvl_d = lvl_q;
    case (sel)
      SEL_SAMPLE: lvl_d = lvl_q ^ wdata;
      SEL_DIR:    dir_d = wdata;
      SEL_LEVEL:  lvl_d = wdata;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         pullup_off,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lvl_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic want_pu;
    assign want_pu    = ~dir_q[i] & lvl_q[i] & ~pullup_off;
    assign pad_oe[i]  = dir_q[i];
    assign pad_out[i] = dir_q[i] & lvl_q[i];
    // pull-up held off for as long as reset is applied
    assign pad_pu[i]  = want_pu & rst_n;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_req,
  input  logic [W-1:0] wake_keep,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);

  logic [W-1:0] clamp;
  logic [W-1:0] gated;
  logic [W-1:0] hold;

  assign clamp = {W{sleep_req}} & ~wake_keep;
  assign gated = pad_in & ~clamp;

  // first stage: open while clk is high, closed while low
  always_latch begin
    if (!rst_n) begin
      hold <= '0;
    end else if (clk) begin
      hold <= gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= hold;
    end
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  input  logic             bus_rd,
  output logic [W-1:0]     bus_rdata,
  input  logic             pullup_off,
  input  logic             sleep_req,
  input  logic [W-1:0]     wake_keep,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_pu
);

  logic [W-1:0] dir_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] pin_q;
  logic [W-1:0] rd_mux;

  gpio_port_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr),
    .sel   (bus_addr),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .lvl_q (lvl_q)
  );

  gpio_pad_ctrl #(.W(W)) u_pads (
    .rst_n      (rst_n),
    .pullup_off (pullup_off),
    .dir_q      (dir_q),
    .lvl_q      (lvl_q),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_keep (wake_keep),
    .pad_in    (pad_in),
    .pin_q     (pin_q)
  );

  always_comb begin
    case (bus_addr)
      SEL_SAMPLE: rd_mux = pin_q;
      SEL_DIR:    rd_mux = dir_q;
      SEL_LEVEL:  rd_mux = lvl_q;
      default:    rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

endmodule

// File: rtl/gpio_port_sync_chk.sv
module gpio_port_sync_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic [W-1:0]     bus_wdata,
  input logic             pullup_off,
  input logic             sleep_req,
  input logic [W-1:0]     wake_keep,
  input logic [W-1:0]     pad_oe,
  input logic [W-1:0]     pad_pu,
  input logic [W-1:0]     dir_q,
  input logic [W-1:0]     lvl_q,
  input logic [W-1:0]     pin_q
);

  always_comb begin
    if (!rst_n) begin
      assert_rst_pullup_R10: assert (pad_pu == '0);
    end
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR) |=> dir_q == $past(bus_wdata));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_SAMPLE) |=> lvl_q == ($past(lvl_q) ^ $past(bus_wdata)));

  assert_pu_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> pad_pu == '0);

  assert_drive_no_pu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  assert_sleep_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_req) |-> (pin_q & ~$past(wake_keep)) == '0);

endmodule

bind gpio_port_sync gpio_port_sync_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .pullup_off (pullup_off),
  .sleep_req  (sleep_req),
  .wake_keep  (wake_keep),
  .pad_oe     (pad_oe),
  .pad_pu     (pad_pu),
  .dir_q      (dir_q),
  .lvl_q      (lvl_q),
  .pin_q      (pin_q)
);

// File: tb/gpio_port_sync_test.sv
module gpio_port_sync_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   bus_addr;
  logic         bus_wr, bus_rd;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic         pullup_off, sleep_req;
  logic [W-1:0] wake_keep, ext, pad_in, pad_oe, pad_out, pad_pu;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] m_dir, m_lvl, m_pin;

  always #10 clk = ~clk;  // 50 MHz

  // pad model: driven level, else pull-up, else external source
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & pad_pu) | (~pad_oe & ~pad_pu & ext);

  gpio_port_sync #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pullup_off(pullup_off), .sleep_req(sleep_req), .wake_keep(wake_keep),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  function automatic logic [W-1:0] exp_pu(logic [W-1:0] d, logic [W-1:0] l, logic po);
    return ~d & l & {W{~po}};
  endfunction

  function automatic logic [W-1:0] exp_pad(logic [W-1:0] d, logic [W-1:0] l, logic po,
                                           logic [W-1:0] e);
    logic [W-1:0] pu;
    pu = exp_pu(d, l, po);
    return (d & l) | pu | (~d & ~pu & e);
  endfunction

  function automatic logic [W-1:0] exp_sample(logic [W-1:0] p, logic s, logic [W-1:0] k);
    return p & ~({W{s}} & ~k);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // one clock: drive, advance past the edge, update the model
  task automatic step(input logic wr, input logic [1:0] a, input logic [W-1:0] wd,
                      input logic [W-1:0] e, input logic s, input logic [W-1:0] k,
                      input logic po);
    logic [W-1:0] nxt;
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ext = e; sleep_req = s; wake_keep = k; pullup_off = po;
    nxt = exp_sample(exp_pad(m_dir, m_lvl, po, e), s, k);
    @(posedge clk); #2;
    bus_wr = 1'b0;
    if (wr) begin
      case (a)
        2'd0: m_lvl = m_lvl ^ wd;
        2'd1: m_dir = wd;
        2'd2: m_lvl = wd;
        default: ;
      endcase
    end
    m_pin = nxt;
  endtask

  task automatic verify_all();
    logic [W-1:0] d;
    rd(2'd1, d); chk("R2 dir", d, m_dir);
    rd(2'd2, d); chk("R2 R3 level", d, m_lvl);
    rd(2'd0, d); chk("R7 R8 R9 sample", d, m_pin);
    rd(2'd3, d); chk("R2 unused", d, '0);
    chk("R6 oe", pad_oe, m_dir);
    chk("R6 out", pad_out, m_dir & m_lvl);
    chk("R4 R5 pu", pad_pu, exp_pu(m_dir, m_lvl, pullup_off));
  endtask

  task automatic do_reset();
    logic [W-1:0] d;
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    #1;
    chk("R10 pu in reset", pad_pu, '0);
    chk("R1 oe in reset", pad_oe, '0);
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    m_dir = '0; m_lvl = '0; m_pin = '0;
    rd(2'd0, d); chk("R1 sample", d, '0);
    rd(2'd1, d); chk("R1 dir", d, '0);
    rd(2'd2, d); chk("R1 level", d, '0);
  endtask

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd4242));
    ext = '0; sleep_req = 1'b0; wake_keep = '0; pullup_off = 1'b0;
    do_reset();

    // R2: read strobe low gives zero
    step(1, 2'd1, 8'h3C, 8'h00, 0, 8'h00, 0);
    bus_addr = 2'd1; bus_rd = 1'b0; #1;
    chk("R2 rd low", bus_rdata, '0);
    verify_all();

    // R4 R5: inputs with and without pull-up
    step(1, 2'd1, 8'h00, 8'h00, 0, 8'h00, 0);
    step(1, 2'd2, 8'hF0, 8'h00, 0, 8'h00, 0);
    chk("R4 oe", pad_oe, 8'h00);
    chk("R5 pu on", pad_pu, 8'hF0);
    step(0, 2'd0, 8'h00, 8'h00, 0, 8'h00, 1);
    chk("R5 pu disabled", pad_pu, 8'h00);
    verify_all();

    // R3: toggle on input-only and output pins
    step(1, 2'd1, 8'h0F, 8'h00, 0, 8'h00, 0);
    step(1, 2'd0, 8'h99, 8'h00, 0, 8'h00, 0);
    rd(2'd2, d); chk("R3 toggle", d, 8'hF0 ^ 8'h99);
    verify_all();

    // R8: output level appears in the sample one cycle late
    step(1, 2'd1, 8'hFF, 8'h00, 0, 8'h00, 0);
    step(1, 2'd2, 8'h00, 8'h00, 0, 8'h00, 0);
    step(0, 2'd0, 8'h00, 8'h00, 0, 8'h00, 0);
    step(1, 2'd2, 8'hA5, 8'h00, 0, 8'h00, 0);
    rd(2'd0, d); chk("R8 old level", d, 8'h00);
    step(0, 2'd0, 8'h00, 8'h00, 0, 8'h00, 0);
    rd(2'd0, d); chk("R8 R7 new level", d, 8'hA5);

    // R9: sleep clamp with partial override
    step(1, 2'd1, 8'h00, 8'hFF, 0, 8'h00, 0);
    step(1, 2'd2, 8'h00, 8'hFF, 1, 8'h0F, 0);
    step(0, 2'd0, 8'h00, 8'hFF, 1, 8'h0F, 0);
    rd(2'd0, d); chk("R9 clamp", d, 8'h0F);
    step(0, 2'd0, 8'h00, 8'hFF, 0, 8'h0F, 0);
    rd(2'd0, d); chk("R9 release", d, 8'hFF);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], W'($urandom), W'($urandom), (r[7:4] == 4'd0),
           W'($urandom), (r[11:8] == 4'd0));
      verify_all();
    end

    // R10: reset asserted mid-run with pull-ups active
    step(1, 2'd1, 8'h00, 8'h00, 0, 8'h00, 0);
    step(1, 2'd2, 8'hFF, 8'h00, 0, 8'h00, 0);
    chk("R5 pu before reset", pad_pu, 8'hFF);
    do_reset();
    verify_all();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule